// File: doc/BRIEF.md
# Delayed L2-to-L1 Line Transfer Controller

This controller tracks the coherence state of one line in a private two-level cache. The two levels are exclusive, so a line lives in either L1 or L2. The stable states are I, S, O, M and MM. A load or instruction fetch can miss in L1 while L1 has room and the L2 tag matches. When that happens, the controller starts an internal move of the line from L2 into the L1 data array or the L1 instruction array. It raises `fill_go` for one cycle, and the surrounding datapath uses that pulse to allocate in L1, copy the line and free the L2 entry. The line then enters a transfer state that records where it came from: IT, ST, OT, MT or MMT.

The line stays in the transfer state for a programmable L2 hit latency, so an L2 hit costs more than an L1 hit. A down-counter loaded from `cfg_lat` measures this latency. When the counter expires, a completion event fires on the trigger queue and the line drops back to its original stable state.

During the transfer, every processor request is turned back with a retry pulse, and snoops from other caches are held off by lowering `snp_ready`. The trigger queue also carries the two acknowledgement-complete events from the miss machinery. The transfer-complete event outranks both of them.

Coherence changes made by the rest of the protocol load the stable state through a state-install port. The state machine has these transitions:
- Reset leads to I.
- From each stable state, the TRANSFER_START transition goes to the matching transfer state.
- From each stable state, the INSTALL transition goes to another stable state.
- From each transfer state, the TRANSFER_DONE transition goes back to its stable state.

Top module: `l2fill_line_ctrl`

## Requirements
- R1: After reset, `line_state` is I (code 0), `snp_ready` is 1, and `fill_go`, `fill_done` and `req_retry` are 0.
- R2: `fill_go` is high in the same cycle when all of these hold: the line is in a stable state, `req_valid` is high, `req_kind` is load (0) or fetch (1), `l1_hit` is 0, `l1_room` is 1 and `l2_tag_hit` is 1. `fill_to_instr` is 1 only with `fill_go` for a fetch. Store (2), L2 replace (3), L1-to-L2 (4) and codes 5 to 7 never start a transfer.
- R3: The `line_state` codes are I=0, S=1, O=2, M=3, MM=4, IT=8, ST=9, OT=10, MT=11 and MMT=12. After a transfer starts, the line takes the transfer code equal to the prior stable code plus 8.
- R4: The line stays in the transfer state for exactly `cfg_lat`+1 cycles, so a latency of 0 completes in the next cycle. `fill_done` is high in the last of those cycles. `cfg_lat` is sampled only when the transfer starts.
- R5: After `fill_done`, `line_state` returns to the stable state the transfer began from.
- R6: In a transfer state, any valid request, of any kind, raises `req_retry` in that cycle and leaves the state and timing unchanged. In a stable state, `req_retry` stays 0.
- R7: `snp_ready` is 0 in every transfer state and 1 in every stable state. `snp_take` equals `snp_valid` AND `snp_ready`.
- R8: A pending acknowledgement on the trigger queue appears on `ack_all` (when `trq_ack_nosh` is 0) or on `ack_all_nosh` (when it is 1), and `trq_ack_ready` is 1. In a cycle where `fill_done` is high, both acknowledgement outputs and `trq_ack_ready` are 0.
- R9: In a stable state, `st_set_valid` with a code from 0 to 4 loads that stable state on the next edge. Codes 5 to 7 are ignored. An install is also ignored in a transfer state and in a cycle where `fill_go` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_kind | input | 3 | Request kind code (see R2) |
| l1_hit | input | 1 | Request hits in L1 |
| l1_room | input | 1 | L1 has a free way for the line |
| l2_tag_hit | input | 1 | L2 tag matches the line |
| snp_valid | input | 1 | Snoop (shared or exclusive read) from another cache |
| cfg_lat | input | LAT_W | L2 hit latency in cycles (default integration value 10) |
| trq_ack_valid | input | 1 | Acknowledgement-complete event pending on trigger queue |
| trq_ack_nosh | input | 1 | Pending acknowledgement is the no-sharers variant |
| st_set_valid | input | 1 | Install stable state from protocol logic |
| st_set_val | input | 3 | Stable state code to install |
| line_state | output | 4 | Current line state code (see R3) |
| fill_go | output | 1 | Transfer start pulse: allocate in L1, copy, free in L2 |
| fill_to_instr | output | 1 | Transfer targets the L1 instruction array |
| fill_done | output | 1 | Transfer-complete event taken from the trigger queue |
| req_retry | output | 1 | Request must be requeued and retried |
| snp_ready | output | 1 | Snoop may be taken (low stalls the snoop at its input) |
| snp_take | output | 1 | Snoop accepted this cycle |
| trq_ack_ready | output | 1 | Acknowledgement event consumed this cycle |
| ack_all | output | 1 | All-acknowledgements event forwarded |
| ack_all_nosh | output | 1 | All-acknowledgements-no-sharers event forwarded |

## Verification
A behavioural reference model is compared against every output on every clock. Transfers are started from each of the five stable states, alternating load and fetch, with latencies of 0, 1, 2, 3, 5 and 10. This separates a wrong transient mapping, a wrong return mapping, and an off-by-one in the hold window. Inside the windows, every request kind is applied along with snoops, mid-flight latency changes, installs and acknowledgements arriving in the completion cycle, which shows whether the window is truly frozen and whether completion outranks acknowledgements. Stable-state cases that must not start a transfer are also applied: store, L1 hit, no room, L2 miss and undefined kinds. A long random phase then mixes all inputs.

// File: rtl/l2fill_pkg.sv
package l2fill_pkg;

    typedef enum logic [3:0] {
        LS_I   = 4'h0,
        LS_S   = 4'h1,
        LS_O   = 4'h2,
        LS_M   = 4'h3,
        LS_MM  = 4'h4,
        LS_IT  = 4'h8,
        LS_ST  = 4'h9,
        LS_OT  = 4'hA,
        LS_MT  = 4'hB,
        LS_MMT = 4'hC
    } line_st_e;

    typedef enum logic [1:0] {
        TE_NONE,
        TE_CMPL,
        TE_ACK,
        TE_ACK_NOSH
    } trq_evt_e;

    localparam logic [2:0] RK_LOAD   = 3'd0;
    localparam logic [2:0] RK_IFETCH = 3'd1;
    localparam logic [2:0] RK_STORE  = 3'd2;
    localparam logic [2:0] RK_L2REPL = 3'd3;
    localparam logic [2:0] RK_L1TOL2 = 3'd4;

    function automatic line_st_e to_transfer(input line_st_e s);
        line_st_e r;
        unique case (s)
            LS_I:    r = LS_IT;
            LS_S:    r = LS_ST;
            LS_O:    r = LS_OT;
            LS_M:    r = LS_MT;
            LS_MM:   r = LS_MMT;
            default: r = s;
        endcase
        return r;
    endfunction

    function automatic line_st_e to_stable(input line_st_e s);
        line_st_e r;
        unique case (s)
            LS_IT:   r = LS_I;
            LS_ST:   r = LS_S;
            LS_OT:   r = LS_O;
            LS_MT:   r = LS_M;
            LS_MMT:  r = LS_MM;
            default: r = s;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/l2fill_req_class.sv
module l2fill_req_class
    import l2fill_pkg::*;
(
    input  logic       req_valid,
    input  logic [2:0] req_kind,
    input  logic       l1_hit,
    input  logic       l1_room,
    input  logic       l2_tag_hit,
    input  logic       st_set_valid,
    input  logic [2:0] st_set_val,
    output logic       trig_req,
    output logic       trig_instr,
    output logic       set_ok,
    output line_st_e   set_state
);

    logic is_read;
    logic l2_candidate;

    always_comb begin
        unique case (req_kind)
            RK_LOAD, RK_IFETCH: is_read = 1'b1;
            RK_STORE, RK_L2REPL, RK_L1TOL2: is_read = 1'b0;
            default: is_read = 1'b0;
        endcase
    end

    assign l2_candidate = !l1_hit && l1_room && l2_tag_hit;
    assign trig_req     = req_valid && is_read && l2_candidate;
    assign trig_instr   = trig_req && (req_kind == RK_IFETCH);

    always_comb begin
        set_ok    = st_set_valid;
        set_state = LS_I;
        unique case (st_set_val)
            3'd0: set_state = LS_I;
            3'd1: set_state = LS_S;
            3'd2: set_state = LS_O;
            3'd3: set_state = LS_M;
            3'd4: set_state = LS_MM;
            default: set_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/l2fill_done_timer.sv
module l2fill_done_timer #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] lat,
    input  logic             active,
    output logic             done
);

    localparam logic [LAT_W-1:0] CNT_ZERO = '0;
    localparam logic [LAT_W-1:0] CNT_ONE  = LAT_W'(1);

    logic [LAT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_ZERO;
        end else if (load) begin
            cnt_q <= lat;
        end else if (active && cnt_q != CNT_ZERO) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    assign done = active && (cnt_q == CNT_ZERO);

endmodule

// File: rtl/l2fill_trq_arb.sv
module l2fill_trq_arb
    import l2fill_pkg::*;
(
    input  logic cmpl_in,
    input  logic ack_valid,
    input  logic ack_nosh,
    output logic cmpl_evt,
    output logic ack_all_o,
    output logic ack_nosh_o,
    output logic ack_ready
);

    trq_evt_e evt;

    always_comb begin
        if (cmpl_in) begin
            evt = TE_CMPL;
        end else if (ack_valid && !ack_nosh) begin
            evt = TE_ACK;
        end else if (ack_valid) begin
            evt = TE_ACK_NOSH;
        end else begin
            evt = TE_NONE;
        end
    end

    always_comb begin
        cmpl_evt   = 1'b0;
        ack_all_o  = 1'b0;
        ack_nosh_o = 1'b0;
        ack_ready  = 1'b0;
        unique case (evt)
            TE_CMPL:     cmpl_evt = 1'b1;
            TE_ACK:      begin ack_all_o  = 1'b1; ack_ready = 1'b1; end
            TE_ACK_NOSH: begin ack_nosh_o = 1'b1; ack_ready = 1'b1; end
            default:     ack_ready = 1'b1;
        endcase
    end

endmodule

// File: rtl/l2fill_line_ctrl.sv
module l2fill_line_ctrl
    import l2fill_pkg::*;
#(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_kind,
    input  logic             l1_hit,
    input  logic             l1_room,
    input  logic             l2_tag_hit,
    input  logic             snp_valid,
    input  logic [LAT_W-1:0] cfg_lat,
    input  logic             trq_ack_valid,
    input  logic             trq_ack_nosh,
    input  logic             st_set_valid,
    input  logic [2:0]       st_set_val,
    output logic [3:0]       line_state,
    output logic             fill_go,
    output logic             fill_to_instr,
    output logic             fill_done,
    output logic             req_retry,
    output logic             snp_ready,
    output logic             snp_take,
    output logic             trq_ack_ready,
    output logic             ack_all,
    output logic             ack_all_nosh
);

    line_st_e st_q, st_d;
    logic     in_xfer;
    logic     trig_req, trig_instr;
    logic     set_ok;
    line_st_e set_state;
    logic     tmr_done;
    logic     cmpl_evt;

    l2fill_req_class u_class (
        .req_valid    (req_valid),
        .req_kind     (req_kind),
        .l1_hit       (l1_hit),
        .l1_room      (l1_room),
        .l2_tag_hit   (l2_tag_hit),
        .st_set_valid (st_set_valid),
        .st_set_val   (st_set_val),
        .trig_req     (trig_req),
        .trig_instr   (trig_instr),
        .set_ok       (set_ok),
        .set_state    (set_state)
    );

    l2fill_done_timer #(.LAT_W(LAT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (fill_go),
        .lat    (cfg_lat),
        .active (in_xfer),
        .done   (tmr_done)
    );

    l2fill_trq_arb u_arb (
        .cmpl_in    (tmr_done),
        .ack_valid  (trq_ack_valid),
        .ack_nosh   (trq_ack_nosh),
        .cmpl_evt   (cmpl_evt),
        .ack_all_o  (ack_all),
        .ack_nosh_o (ack_all_nosh),
        .ack_ready  (trq_ack_ready)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= LS_I;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state: TRANSFER_START, INSTALL, TRANSFER_DONE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LS_I, LS_S, LS_O, LS_M, LS_MM: begin
                if (trig_req) begin
                    st_d = to_transfer(st_q);
                end else if (set_ok) begin
                    st_d = set_state;
                end
            end
            LS_IT, LS_ST, LS_OT, LS_MT, LS_MMT: begin
                if (cmpl_evt) begin
                    st_d = to_stable(st_q);
                end
            end
            default: st_d = LS_I;
        endcase
    end

    // Outputs
    always_comb begin
        in_xfer       = 1'b0;
        fill_go       = 1'b0;
        fill_to_instr = 1'b0;
        req_retry     = 1'b0;
        unique case (st_q)
            LS_I, LS_S, LS_O, LS_M, LS_MM: begin
                fill_go       = trig_req;
                fill_to_instr = trig_instr;
            end
            LS_IT, LS_ST, LS_OT, LS_MT, LS_MMT: begin
                in_xfer   = 1'b1;
                req_retry = req_valid;
            end
            default: ;
        endcase
    end

    assign line_state = st_q;
    assign fill_done  = cmpl_evt;
    assign snp_ready  = !in_xfer;
    assign snp_take   = snp_valid && !in_xfer;

endmodule

// File: rtl/l2fill_line_ctrl_chk.sv
module l2fill_line_ctrl_chk #(
    parameter int LAT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             snp_valid,
    input logic [LAT_W-1:0] cfg_lat,
    input logic [3:0]       line_state,
    input logic             fill_go,
    input logic             fill_done,
    input logic             req_retry,
    input logic             snp_ready,
    input logic             snp_take,
    input logic             trq_ack_ready,
    input logic             ack_all,
    input logic             ack_all_nosh
);

    logic [LAT_W:0]   win_cnt;
    logic [LAT_W-1:0] win_lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt <= '0;
            win_lat <= '0;
        end else if (fill_go) begin
            win_cnt <= '0;
            win_lat <= cfg_lat;
        end else if (line_state[3]) begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    AST_NO_DOUBLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        fill_go |-> !line_state[3]); // R2
    AST_ENTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fill_go |=> line_state == {1'b1, $past(line_state[2:0])}); // R3
    AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> win_cnt == {1'b0, win_lat}); // R4
    AST_RETURN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> line_state == {1'b0, $past(line_state[2:0])}); // R5
    AST_RETRY_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && line_state[3]) |-> (req_retry && !fill_go)); // R6
    AST_SNOOP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        line_state[3] |-> (!snp_ready && !snp_take)); // R7
    AST_SNOOP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_state[3] && snp_valid) |-> snp_take); // R7
    AST_CMPL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> (!ack_all && !ack_all_nosh && !trq_ack_ready)); // R8
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_all, ack_all_nosh, fill_done})); // R8

endmodule

bind l2fill_line_ctrl l2fill_line_ctrl_chk #(.LAT_W(LAT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .snp_valid     (snp_valid),
    .cfg_lat       (cfg_lat),
    .line_state    (line_state),
    .fill_go       (fill_go),
    .fill_done     (fill_done),
    .req_retry     (req_retry),
    .snp_ready     (snp_ready),
    .snp_take      (snp_take),
    .trq_ack_ready (trq_ack_ready),
    .ack_all       (ack_all),
    .ack_all_nosh  (ack_all_nosh)
);

// File: tb/l2fill_line_ctrl_test.sv
module l2fill_line_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int LAT_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 0;
    logic [2:0]       req_kind = 0;
    logic             l1_hit = 0, l1_room = 0, l2_tag_hit = 0;
    logic             snp_valid = 0;
    logic [LAT_W-1:0] cfg_lat = 0;
    logic             trq_ack_valid = 0, trq_ack_nosh = 0;
    logic             st_set_valid = 0;
    logic [2:0]       st_set_val = 0;
    logic [3:0]       line_state;
    logic             fill_go, fill_to_instr, fill_done, req_retry;
    logic             snp_ready, snp_take, trq_ack_ready, ack_all, ack_all_nosh;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    l2fill_line_ctrl #(.LAT_W(LAT_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .l1_hit(l1_hit), .l1_room(l1_room), .l2_tag_hit(l2_tag_hit),
        .snp_valid(snp_valid), .cfg_lat(cfg_lat),
        .trq_ack_valid(trq_ack_valid), .trq_ack_nosh(trq_ack_nosh),
        .st_set_valid(st_set_valid), .st_set_val(st_set_val),
        .line_state(line_state), .fill_go(fill_go), .fill_to_instr(fill_to_instr),
        .fill_done(fill_done), .req_retry(req_retry), .snp_ready(snp_ready),
        .snp_take(snp_take), .trq_ack_ready(trq_ack_ready),
        .ack_all(ack_all), .ack_all_nosh(ack_all_nosh)
    );

    // Reference model
    int m_base = 0;
    bit m_tr = 0;
    int m_cnt = 0;

    function automatic bit m_trig();
        return !m_tr && req_valid && (req_kind == 0 || req_kind == 1)
               && !l1_hit && l1_room && l2_tag_hit;
    endfunction

    function automatic bit m_done();
        return m_tr && (m_cnt == 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_base = 0; m_tr = 0; m_cnt = 0;
        end else if (m_tr) begin
            if (m_cnt == 0) m_tr = 0;
            else m_cnt = m_cnt - 1;
        end else if (m_trig()) begin
            m_tr = 1; m_cnt = int'(cfg_lat);
        end else if (st_set_valid && st_set_val <= 3'd4) begin
            m_base = int'(st_set_val);
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R5", "line_state", int'(line_state), (m_tr ? 8 : 0) + m_base);
            chk("R2", "fill_go", int'(fill_go), int'(m_trig()));
            chk("R2", "fill_to_instr", int'(fill_to_instr), int'(m_trig() && req_kind == 1));
            chk("R4", "fill_done", int'(fill_done), int'(m_done()));
            chk("R6", "req_retry", int'(req_retry), int'(m_tr && req_valid));
            chk("R7", "snp_ready", int'(snp_ready), int'(!m_tr));
            chk("R7", "snp_take", int'(snp_take), int'(!m_tr && snp_valid));
            chk("R8", "ack_all", int'(ack_all), int'(trq_ack_valid && !trq_ack_nosh && !m_done()));
            chk("R8", "ack_all_nosh", int'(ack_all_nosh), int'(trq_ack_valid && trq_ack_nosh && !m_done()));
            chk("R8", "trq_ack_ready", int'(trq_ack_ready), int'(!m_done()));
        end
    end

    task automatic summary();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    // Drive one cycle of inputs (called at posedge+1), then advance.
    task automatic step(input bit rv, input int kind, input bit hit1, input bit room,
                        input bit hit2, input bit snp, input int lat, input bit av,
                        input bit an, input bit sv, input int sval);
        req_valid = rv; req_kind = 3'(kind); l1_hit = hit1; l1_room = room;
        l2_tag_hit = hit2; snp_valid = snp; cfg_lat = LAT_W'(lat);
        trq_ack_valid = av; trq_ack_nosh = an; st_set_valid = sv; st_set_val = 3'(sval);
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic install(input int v);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, v);
    endtask

    task automatic start(input int kind, input int lat);
        step(1, kind, 0, 1, 1, 0, lat, 0, 0, 0, 0);
    endtask

    initial begin
        #1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset line_state", int'(line_state), 0);
        chk("R1", "reset snp_ready", int'(snp_ready), 1);
        chk("R1", "reset fill_go", int'(fill_go), 0);
        chk("R1", "reset fill_done", int'(fill_done), 0);
        chk("R1", "reset req_retry", int'(req_retry), 0);
        @(posedge clk); #1;
        rst_n = 1;
        idle(2);

        // S, load, latency 3; every kind retried inside the window
        install(1);
        chk("R9", "install S", int'(line_state), 1);
        start(0, 3);
        chk("R3", "S to ST", int'(line_state), 9);
        for (int k = 0; k < 4; k++) begin
            step(1, k, 0, 1, 1, 1, 7, 0, 0, 0, 0);
            if (k < 3) chk("R4", "still ST", int'(line_state), 9);
        end
        chk("R5", "back to S", int'(line_state), 1);

        // S, fetch, latency 2; install during transfer ignored
        start(1, 2);
        chk("R3", "ST again", int'(line_state), 9);
        install(3);
        chk("R9", "install ignored in transfer", int'(line_state), 9);
        idle(2);
        chk("R5", "S kept", int'(line_state), 1);

        // Invalid install code ignored
        install(6);
        chk("R9", "code 6 ignored", int'(line_state), 1);

        // M, latency 0, ack in completion cycle, L1-to-L2 retried
        install(3);
        start(0, 0);
        chk("R3", "M to MT", int'(line_state), 11);
        step(1, 4, 0, 1, 1, 1, 0, 1, 0, 0, 0);
        chk("R4", "latency 0 done", int'(line_state), 3);
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);

        // MM, latency 10, latency input changes mid-flight
        install(4);
        start(1, 10);
        chk("R3", "MM to MMT", int'(line_state), 12);
        for (int i = 0; i < 11; i++) begin
            step(0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0);
            if (i == 9) chk("R4", "MMT at cycle 11", int'(line_state), 12);
        end
        chk("R4", "MM after 11 cycles", int'(line_state), 4);

        // O, latency 1, install on the start cycle ignored
        install(2);
        step(1, 0, 0, 1, 1, 0, 1, 0, 0, 1, 0);
        chk("R9", "install on start ignored", int'(line_state), 10);
        idle(2);
        chk("R5", "back to O", int'(line_state), 2);

        // I, latency 5
        install(0);
        start(1, 5);
        chk("R3", "I to IT", int'(line_state), 8);
        idle(6);
        chk("R5", "back to I", int'(line_state), 0);

        // Stable-state requests that must not start a transfer
        install(1);
        step(1, 2, 0, 1, 1, 0, 3, 0, 0, 0, 0);
        step(1, 0, 1, 1, 1, 0, 3, 0, 0, 0, 0);
        step(1, 0, 0, 0, 1, 0, 3, 0, 0, 0, 0);
        step(1, 1, 0, 1, 0, 0, 3, 0, 0, 0, 0);
        step(1, 5, 0, 1, 1, 0, 3, 0, 0, 0, 0);
        step(1, 3, 0, 1, 1, 1, 3, 1, 1, 0, 0);
        chk("R2", "no transfer started", int'(line_state), 1);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 3) == 0,
                 $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, $urandom_range(0, 1),
                 $urandom_range(0, 6), $urandom_range(0, 1), $urandom_range(0, 1),
                 $urandom_range(0, 3) == 0, $urandom_range(0, 7));
        end
        idle(20);

        summary();
        $finish;
    end

endmodule